// File: doc/BRIEF.md
# Power Supervisor Reset Sequencer

This block is the digital half of a supply monitor. Two comparator outputs come in as plain inputs. One says the supply is above the reset threshold. The other says the supply is above a higher warning threshold. The block turns them into three things: a system reset, a power-fail warning flag with an optional interrupt request, and a sticky power-on flag.

Reset is held for as long as the supply is below the reset threshold. After the supply recovers, reset stays held for a fixed run of clocks, and it is released only when that run completes without a dip. The warning flag tracks the upper comparator. Software can use it to save state before the supply falls far enough to force a reset.

A single control register gives software four things. It can clear both flags, enable the interrupt, and choose whether monitoring stays alive while the chip is in stop mode.

Top module: `pwr_supervisor`

## Requirements
- R1: `sys_rst_o` is high whenever the synchronized reset-threshold comparator is low and monitoring is active. No register bit can mask it.
- R2: Once the comparator input rises, reset is released after `STARTUP_CYCLES` consecutive clocks with the supply good. `STARTUP_CYCLES` defaults to 65536. The input passes a two-flop synchronizer, so `sys_rst_o` falls after the (STARTUP_CYCLES+2)-th rising edge following the input change, and not earlier.
- R3: A dip of the reset-threshold comparator during the startup run clears the count. The full run then restarts from the moment the supply is good again.
- R4: The power-on flag is bit 1 of the register at address 0. It is set at every reset release that ends a startup run, and it stays set until software writes 0 to bit 1. Writing 1 to it has no effect.
- R5: The power-fail flag is bit 0 of the register at address 0. It is set while the synchronized warning comparator is low, and a write of 0 during that time does not leave it clear. After the supply recovers, it stays set until software writes 0, and then it reads 0.
- R6: On a supply that falls past the warning level before the reset level, the power-fail flag reads 1 while `sys_rst_o` is still low.
- R7: `pfail_irq_o` is high exactly when the power-fail flag and the enable bit (bit 2, read/write) are both 1. The flag updates whatever the enable holds.
- R8: Bit 3 (read/write, reset 0) keeps monitoring alive in stop. With `stop_i` high and bit 3 at 0, low comparators cause neither reset nor a power-fail flag. With bit 3 at 1, both act as usual.
- R9: Only address 0 is decoded. Reads of any other address return 0, and writes to any other address change nothing.
- R10: While `rst_n` is low, `sys_rst_o` is 1, `pfail_irq_o` is 0 and the register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| vrst_ok_i | input | 1 | Comparator: supply above reset threshold |
| vwarn_ok_i | input | 1 | Comparator: supply above warning threshold |
| stop_i | input | 1 | Chip is in stop mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| sys_rst_o | output | 1 | System reset, active high |
| pfail_irq_o | output | 1 | Power-fail interrupt request |

## Verification
The warning path is driven from a table of supply levels, flag clears and enable settings. That table tells apart a flag that merely follows the comparator, a flag that is truly sticky after recovery, and a clear that is overridden while the supply is still low. The table also shows that the interrupt gate is independent of flag updates. The startup path is tried with a clean rise and with a one-clock dip halfway through the count. Sampling exactly one clock before and at the expected release separates a restarting counter from one that only pauses. Stop mode is tried with the keep-alive bit at both values, and an off-map write shows that decoding is limited to address 0.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned BIT_PF   = 0;
  localparam int unsigned BIT_POR  = 1;
  localparam int unsigned BIT_IEN  = 2;
  localparam int unsigned BIT_KEEP = 3;

  typedef struct packed {
    logic keep;
    logic irq_en;
    logic por;
    logic pf;
  } ctrl_t;
endpackage

// File: rtl/pwrsup_sync.sv
module pwrsup_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwrsup_startup.sv
module pwrsup_startup #(
  parameter int unsigned STARTUP_CYCLES = 65536,
  parameter int unsigned CNT_W          = $clog2(STARTUP_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_low_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hold_o,
  output logic             release_o
);
  localparam logic [CNT_W-1:0] TERM     = CNT_W'(STARTUP_CYCLES);
  localparam logic [CNT_W-1:0] TERM_M1  = CNT_W'(STARTUP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             done;

  assign done = (cnt_q == TERM);

  always_comb begin
    cnt_en = supply_low_i || !done;
    if (supply_low_i) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign hold_o    = supply_low_i || !done;
  assign release_o = !supply_low_i && (cnt_q == TERM_M1);
endmodule

// File: rtl/pwrsup_regs.sv
module pwrsup_regs
  import pwrsup_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warn_low_i,
  input  logic              por_set_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o
);
  localparam int unsigned PAD_W = REG_W - $bits(ctrl_t);

  ctrl_t ctrl_q, ctrl_d;
  logic  sel;
  logic  hit;

  assign sel = (addr_i == '0);
  assign hit = we_i && sel;

  always_comb begin
    ctrl_d        = ctrl_q;
    // Set sources win over a software clear in the same cycle.
    ctrl_d.pf     = warn_low_i || (ctrl_q.pf  && !(hit && !wdata_i[BIT_PF]));
    ctrl_d.por    = por_set_i  || (ctrl_q.por && !(hit && !wdata_i[BIT_POR]));
    if (hit) begin
      ctrl_d.irq_en = wdata_i[BIT_IEN];
      ctrl_d.keep   = wdata_i[BIT_KEEP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign rdata_o = sel ? {{PAD_W{1'b0}}, ctrl_q} : '0;
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwrsup_pkg::*;
#(
  parameter int unsigned STARTUP_CYCLES = 65536,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned ADDR_W         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vrst_ok_i,
  input  logic              vwarn_ok_i,
  input  logic              stop_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              sys_rst_o,
  output logic              pfail_irq_o
);
  localparam int unsigned CNT_W = $clog2(STARTUP_CYCLES + 1);

  logic [1:0]       cmp_s;
  logic             rst_ok_s, warn_ok_s;
  logic             monitor_on;
  logic             supply_low, warn_low;
  logic [CNT_W-1:0] start_cnt;
  logic             hold, rel_pulse;
  ctrl_t            ctrl;

  pwrsup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({vwarn_ok_i, vrst_ok_i}),
    .q_o   (cmp_s)
  );

  assign rst_ok_s   = cmp_s[0];
  assign warn_ok_s  = cmp_s[1];
  assign monitor_on = !stop_i || ctrl.keep;
  assign supply_low = monitor_on && !rst_ok_s;
  assign warn_low   = monitor_on && !warn_ok_s;

  pwrsup_startup #(.STARTUP_CYCLES(STARTUP_CYCLES), .CNT_W(CNT_W)) u_start (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_low_i (supply_low),
    .cnt_o        (start_cnt),
    .hold_o       (hold),
    .release_o    (rel_pulse)
  );

  pwrsup_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .warn_low_i (warn_low),
    .por_set_i  (rel_pulse),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .ctrl_o     (ctrl)
  );

  assign sys_rst_o   = hold;
  assign pfail_irq_o = ctrl.pf && ctrl.irq_en;
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
  parameter int unsigned STARTUP_CYCLES = 65536,
  parameter int unsigned ADDR_W         = 2,
  parameter int unsigned CNT_W          = $clog2(STARTUP_CYCLES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_low,
  input logic              warn_low,
  input logic [CNT_W-1:0]  start_cnt,
  input logic              sys_rst_o,
  input logic              pf_flag,
  input logic              por_flag,
  input logic              irq_en,
  input logic              keep,
  input logic              stop_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_wdata_i
);
  // R3: a low supply clears the startup count on the next edge
  a_r3_low_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> (start_cnt == '0));

  // R2: reset falls only right after the count reached its last step
  a_r2_release_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> ($past(start_cnt) == CNT_W'(STARTUP_CYCLES - 1)));

  // R5: a low warning comparator leaves the flag set
  a_r5_warn_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    warn_low |=> pf_flag);

  // R4: power-on flag holds unless zero is written to it
  a_r4_por_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (por_flag && !(reg_we_i && reg_addr_i == '0 && !reg_wdata_i[1])) |=> por_flag);

  // R8: in stop without keep-alive, a released system stays released
  a_r8_stop_masks_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !keep && !$past(sys_rst_o)) |-> !sys_rst_o);

  // R9: writes to other addresses leave the control bits alone
  a_r9_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i != '0) |=> $stable({irq_en, keep}));
endmodule

bind pwr_supervisor pwr_supervisor_chk #(
  .STARTUP_CYCLES (STARTUP_CYCLES),
  .ADDR_W         (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_low  (supply_low),
  .warn_low    (warn_low),
  .start_cnt   (start_cnt),
  .sys_rst_o   (sys_rst_o),
  .pf_flag     (ctrl.pf),
  .por_flag    (ctrl.por),
  .irq_en      (ctrl.irq_en),
  .keep        (ctrl.keep),
  .stop_i      (stop_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i)
);

// File: tb/sim_pwr_supervisor.sv
module sim_pwr_supervisor;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N          = 32;
  localparam int unsigned ADDR_W     = 2;
  localparam int unsigned WATCHDOG   = 20000;

  // [4] warn comparator, [3] clear pf, [2] irq enable, [1] expected pf, [0] expected irq
  localparam logic [4:0] VEC [8] = '{
    5'b11000, 5'b00010, 5'b00111, 5'b01111,
    5'b10111, 5'b11100, 5'b10100, 5'b00010
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              vrst_ok, vwarn_ok, stop;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata;
  logic [7:0]        rdata;
  logic              sys_rst, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_supervisor #(.STARTUP_CYCLES(N), .SYNC_STAGES(2), .ADDR_W(ADDR_W)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .vrst_ok_i   (vrst_ok),
    .vwarn_ok_i  (vwarn_ok),
    .stop_i      (stop),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .sys_rst_o   (sys_rst),
    .pfail_irq_o (irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      report();
    end
  end

  initial begin
    rst_n = 1'b0; vrst_ok = 1'b0; vwarn_ok = 1'b0; stop = 1'b0;
    we = 1'b0; addr = '0; wdata = '0;
    wait_neg(3);
    // R10 reset state
    check("R10 sys_rst", {7'b0, sys_rst}, 8'h01);
    check("R10 rdata", rdata, 8'h00);
    check("R10 irq", {7'b0, irq}, 8'h00);

    rst_n = 1'b1;
    wait_neg(4);
    check("R1 low supply holds reset", {7'b0, sys_rst}, 8'h01);

    // R2 clean power-up
    @(negedge clk); vrst_ok = 1'b1; vwarn_ok = 1'b1;
    for (int i = 0; i < N + 1; i++) @(posedge clk);
    @(negedge clk);
    check("R2 one clock before release", {7'b0, sys_rst}, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R2 released", {7'b0, sys_rst}, 8'h00);
    check("R4 por set on release", rdata, 8'h03);

    // R5 / R7 vector table
    for (int v = 0; v < 8; v++) begin
      logic [4:0] e;
      e = VEC[v];
      @(negedge clk); vwarn_ok = e[4];
      wr('0, {5'b0, e[2], 2'b11});
      wait_neg(3);
      if (e[3]) wr('0, {5'b0, e[2], 2'b10});
      check($sformatf("R5 pf flag vec%0d", v), {7'b0, rdata[0]}, {7'b0, e[1]});
      check($sformatf("R7 irq vec%0d", v), {7'b0, irq}, {7'b0, e[0]});
    end

    // R4 clear and write-one behaviour
    @(negedge clk); vwarn_ok = 1'b1;
    wait_neg(3);
    wr('0, 8'h02);
    wr('0, 8'h01);
    check("R4 por cleared by zero", rdata, 8'h00);
    wr('0, 8'h02);
    check("R4 write one no effect", rdata, 8'h00);

    // R9 other address
    wr(2'd1, 8'h0C);
    check("R9 ctrl unchanged", rdata, 8'h00);
    @(negedge clk); addr = 2'd1;
    #1 check("R9 other address reads zero", rdata, 8'h00);
    addr = '0;

    // R6 ordered fall
    @(negedge clk); vwarn_ok = 1'b0;
    wait_neg(4);
    check("R6 flag before reset", {7'b0, rdata[0]}, 8'h01);
    check("R6 reset not yet", {7'b0, sys_rst}, 8'h00);
    @(negedge clk); vrst_ok = 1'b0;
    wait_neg(3);
    check("R1 reset on low supply", {7'b0, sys_rst}, 8'h01);

    // R3 dip during startup
    @(negedge clk); vrst_ok = 1'b1; vwarn_ok = 1'b1;
    wait_neg(N / 2);
    vrst_ok = 1'b0;
    @(negedge clk); vrst_ok = 1'b1;
    for (int i = 0; i < N + 1; i++) @(posedge clk);
    @(negedge clk);
    check("R3 count restarted", {7'b0, sys_rst}, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R3 released after full run", {7'b0, sys_rst}, 8'h00);
    check("R4 por set again", rdata, 8'h03);
    wr('0, 8'h00);
    check("R5 flags cleared after recovery", rdata, 8'h00);

    // R8 stop mode gating
    @(negedge clk); stop = 1'b1; vrst_ok = 1'b0; vwarn_ok = 1'b0;
    wait_neg(5);
    check("R8 no reset in stop", {7'b0, sys_rst}, 8'h00);
    check("R8 no flag in stop", rdata, 8'h00);
    wr('0, 8'h0B);
    wait_neg(2);
    check("R8 keep-alive reset", {7'b0, sys_rst}, 8'h01);
    check("R8 keep-alive flag", rdata, 8'h09);

    @(negedge clk); stop = 1'b0; vrst_ok = 1'b1; vwarn_ok = 1'b1;
    wait_neg(4);
    report();
  end
endmodule